// File: doc/BRIEF.md
# Configurable Polynomial CRC Engine

This block is a CRC calculator attached to a simple register bus. The bus has an address, a write strobe, four byte-lane enables, write data and combinational read data. Software sets the generator polynomial, its degree (32, 16, 8 or 7) and a start value. It can also choose an input bit reordering and an output mirror. It then writes payload to the data register as words, half-words or bytes. Each write is folded into the running remainder in the clock in which it is accepted. Reading the data register returns the current remainder.

The remainder is computed MSB-first, with no implied reflection. Only the low N bits of the polynomial register are used, where N is the selected degree, and the result sits in the low N bits. Reflected CRC variants are built by combining the input reordering with the output mirror. An 8-bit scratch register is provided for software and has no effect on the calculation.

Top module: `crc_unit`

## Requirements
- R1: After reset, the data register reads 0xFFFFFFFF, the start-value register (offset 0x10) reads 0xFFFFFFFF, the polynomial register (offset 0x14) reads 0x04C11DB7, and the control register (offset 0x08) reads 0.
- R2: Writing control (offset 0x08, lane 0) with bit 0 set loads the remainder from the start-value register in the same write. Bit 0 always reads back as 0. Control bits 7:3 read back as written, and all other bits read 0.
- R3: A write to the data register (offset 0x00) with all four lane enables set folds 32 bits MSB-first: for each bit b, feedback = rem[N-1] xor b, rem = (rem << 1) masked to N bits, and when feedback is 1, rem ^= poly masked to N bits.
- R4: Lane enables 4'b0011 fold only data[15:0], and lane enable 4'b0001 folds only data[7:0], in both cases from the top bit of that width down.
- R5: A data write with any other lane-enable pattern leaves the remainder unchanged.
- R6: Control bits 4:3 select the degree: 0 for 32, 1 for 16, 2 for 8 and 3 for 7. For degrees below 32, the data register reads the remainder in its low N bits, with zeros above.
- R7: Control bits 6:5 select input reordering before folding: 0 for none, 1 to reverse bits within each byte, 2 within each half-word, 3 across all 32 bits. The reversal unit is the smaller of the selected unit and the write width.
- R8: When control bit 7 is set, a data-register read returns the N active remainder bits in reversed order; the upper bits still read zero.
- R9: The scratch register (offset 0x04, lane 0) stores 8 bits, reads back in bits 7:0, and changes neither the remainder nor the configuration.
- R10: Data writes on consecutive clocks are each folded, with no wait state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wr | input | 1 | Write strobe for this cycle |
| bus_be | input | 4 | Byte-lane enables of the write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |

## Verification
The hardest cases to reach from the ports combine a narrow write width with a wider reversal unit, and a small degree with output mirroring. In these cases the reversal unit, the active bit count and the mirror width all differ from one another. The stimulus first walks every reversal mode against every write width, and every degree with the mirror on and off, each using its own polynomial. It then runs a long seeded random mix in which configuration changes, start-value reloads and invalid lane patterns are interleaved with back-to-back data writes.

// File: rtl/crc_unit_pkg.sv
package crc_unit_pkg;
   typedef enum logic [1:0] {SZ_32 = 2'd0, SZ_16 = 2'd1, SZ_8 = 2'd2, SZ_7 = 2'd3} crc_size_e;
   typedef enum logic [1:0] {RV_NONE = 2'd0, RV_BYTE = 2'd1, RV_HALF = 2'd2, RV_WORD = 2'd3} crc_rev_e;
   typedef enum logic [1:0] {WD_NONE = 2'd0, WD_8 = 2'd1, WD_16 = 2'd2, WD_32 = 2'd3} crc_width_e;

   function automatic logic [31:0] size_mask(input crc_size_e sz);
      case (sz)
         SZ_16:   size_mask = 32'h0000_FFFF;
         SZ_8:    size_mask = 32'h0000_00FF;
         SZ_7:    size_mask = 32'h0000_007F;
         default: size_mask = 32'hFFFF_FFFF;
      endcase
   endfunction

   function automatic logic [4:0] size_top(input crc_size_e sz);
      case (sz)
         SZ_16:   size_top = 5'd15;
         SZ_8:    size_top = 5'd7;
         SZ_7:    size_top = 5'd6;
         default: size_top = 5'd31;
      endcase
   endfunction
endpackage

// File: rtl/crc_in_reorder.sv
module crc_in_reorder
   import crc_unit_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  crc_rev_e          mode,
   input  crc_width_e        width,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout
);
   localparam int BYTES = DATA_W / 8;
   localparam int HALVES = DATA_W / 16;

   if (DATA_W != 32) begin : g_bad_width
      $error("crc_in_reorder supports DATA_W of 32 only");
   end

   logic [DATA_W-1:0] rev_b, rev_h, rev_w;
   logic [1:0]        unit;

   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      assign rev_b[(i/8)*8 + 7 - (i%8)]    = din[i];
      assign rev_h[(i/16)*16 + 15 - (i%16)] = din[i];
      assign rev_w[DATA_W-1-i]              = din[i];
   end

   // smaller of mode unit and write width
   assign unit = (mode < width) ? mode : width;

   always_comb begin
      case (unit)
         2'd1:    dout = rev_b;
         2'd2:    dout = rev_h;
         2'd3:    dout = rev_w;
         default: dout = din;
      endcase
   end

   initial begin
      if (BYTES != 2 * HALVES) $error("crc_in_reorder lane count mismatch");
   end
endmodule

// File: rtl/crc_fold.sv
module crc_fold
   import crc_unit_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] rem_in,
   input  logic [DATA_W-1:0] poly,
   input  crc_size_e         size,
   input  crc_width_e        width,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] rem_out
);
   localparam int STEPS = DATA_W;

   if (DATA_W != 32) begin : g_bad_width
      $error("crc_fold supports DATA_W of 32 only");
   end

   logic [DATA_W-1:0] mask, pmask, aligned;
   logic [4:0]        top;
   logic [5:0]        nbits;
   logic [DATA_W-1:0] stage [STEPS+1];

   assign mask  = size_mask(size);
   assign pmask = poly & mask;
   assign top   = size_top(size);

   always_comb begin
      case (width)
         WD_8:    begin nbits = 6'd8;  aligned = {din[7:0], 24'h0};  end
         WD_16:   begin nbits = 6'd16; aligned = {din[15:0], 16'h0}; end
         WD_32:   begin nbits = 6'd32; aligned = din;                end
         default: begin nbits = 6'd0;  aligned = '0;                 end
      endcase
   end

   assign stage[0] = rem_in & mask;

   for (genvar i = 0; i < STEPS; i++) begin : g_step
      logic fb;
      logic [DATA_W-1:0] shifted;
      assign fb      = stage[i][top] ^ aligned[DATA_W-1-i];
      assign shifted = (stage[i] << 1) & mask;
      assign stage[i+1] = (i < int'(nbits)) ? (fb ? (shifted ^ pmask) : shifted) : stage[i];
   end

   assign rem_out = stage[STEPS];
endmodule

// File: rtl/crc_out_mirror.sv
module crc_out_mirror
   import crc_unit_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              enable,
   input  crc_size_e         size,
   input  logic [DATA_W-1:0] rem,
   output logic [DATA_W-1:0] dout
);
   logic [DATA_W-1:0] masked, full_rev, shifted;
   logic [5:0]        drop;

   assign masked = rem & size_mask(size);

   for (genvar i = 0; i < DATA_W; i++) begin : g_rev
      assign full_rev[DATA_W-1-i] = masked[i];
   end

   assign drop    = 6'd31 - {1'b0, size_top(size)};
   assign shifted = full_rev >> drop;
   assign dout    = enable ? shifted : masked;
endmodule

// File: rtl/crc_unit.sv
module crc_unit
   import crc_unit_pkg::*;
#(
   parameter int          ADDR_W   = 8,
   parameter logic [31:0] RST_INIT = 32'hFFFF_FFFF,
   parameter logic [31:0] RST_POLY = 32'h04C1_1DB7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [3:0]        bus_be,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata
);
   localparam int DATA_W = 32;
   localparam int LANES  = DATA_W / 8;
   localparam logic [ADDR_W-1:0] OFS_DATA = ADDR_W'(8'h00);
   localparam logic [ADDR_W-1:0] OFS_SCR  = ADDR_W'(8'h04);
   localparam logic [ADDR_W-1:0] OFS_CTRL = ADDR_W'(8'h08);
   localparam logic [ADDR_W-1:0] OFS_INIT = ADDR_W'(8'h10);
   localparam logic [ADDR_W-1:0] OFS_POLY = ADDR_W'(8'h14);

   if (ADDR_W < 5) begin : g_bad_addr
      $error("crc_unit needs ADDR_W of at least 5");
   end

   logic [DATA_W-1:0] rem_q, init_q, poly_q, rem_next, din_ord, rd_rem;
   logic [7:0]        scr_q;
   crc_size_e         size_q;
   crc_rev_e          revi_q;
   logic              revo_q;
   crc_width_e        width;
   logic              wr_data, wr_scr, wr_ctrl, wr_init, wr_poly, reload;

   assign wr_data = bus_wr && (bus_addr == OFS_DATA);
   assign wr_scr  = bus_wr && (bus_addr == OFS_SCR) && bus_be[0];
   assign wr_ctrl = bus_wr && (bus_addr == OFS_CTRL) && bus_be[0];
   assign wr_init = bus_wr && (bus_addr == OFS_INIT);
   assign wr_poly = bus_wr && (bus_addr == OFS_POLY);
   assign reload  = wr_ctrl && bus_wdata[0];

   always_comb begin
      case (bus_be)
         4'b1111: width = WD_32;
         4'b0011: width = WD_16;
         4'b0001: width = WD_8;
         default: width = WD_NONE;
      endcase
   end

   crc_in_reorder #(.DATA_W(DATA_W)) u_reorder (
      .mode  (revi_q),
      .width (width),
      .din   (bus_wdata),
      .dout  (din_ord)
   );

   crc_fold #(.DATA_W(DATA_W)) u_fold (
      .rem_in  (rem_q),
      .poly    (poly_q),
      .size    (size_q),
      .width   (width),
      .din     (din_ord),
      .rem_out (rem_next)
   );

   crc_out_mirror #(.DATA_W(DATA_W)) u_mirror (
      .enable (revo_q),
      .size   (size_q),
      .rem    (rem_q),
      .dout   (rd_rem)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q  <= RST_INIT;
         scr_q  <= '0;
         size_q <= SZ_32;
         revi_q <= RV_NONE;
         revo_q <= 1'b0;
      end else begin
         if (reload)
            rem_q <= init_q;
         else if (wr_data && width != WD_NONE)
            rem_q <= rem_next;
         if (wr_scr)
            scr_q <= bus_wdata[7:0];
         if (wr_ctrl) begin
            size_q <= crc_size_e'(bus_wdata[4:3]);
            revi_q <= crc_rev_e'(bus_wdata[6:5]);
            revo_q <= bus_wdata[7];
         end
      end
   end

   for (genvar b = 0; b < LANES; b++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            init_q[8*b +: 8] <= RST_INIT[8*b +: 8];
            poly_q[8*b +: 8] <= RST_POLY[8*b +: 8];
         end else begin
            if (wr_init && bus_be[b]) init_q[8*b +: 8] <= bus_wdata[8*b +: 8];
            if (wr_poly && bus_be[b]) poly_q[8*b +: 8] <= bus_wdata[8*b +: 8];
         end
      end
   end

   always_comb begin
      case (bus_addr)
         OFS_DATA: bus_rdata = rd_rem;
         OFS_SCR:  bus_rdata = {24'h0, scr_q};
         OFS_CTRL: bus_rdata = {24'h0, revo_q, revi_q, size_q, 3'b000};
         OFS_INIT: bus_rdata = init_q;
         OFS_POLY: bus_rdata = poly_q;
         default:  bus_rdata = '0;
      endcase
   end

   p_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == OFS_CTRL && bus_be[0] && bus_wdata[0]) |=> (rem_q == $past(init_q)));

   p_bad_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == OFS_DATA && bus_be != 4'hF && bus_be != 4'h3 && bus_be != 4'h1)
      |=> $stable(rem_q));

   // R9: anything other than a data write or reload keeps the remainder
   p_rem_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!(bus_wr && bus_addr == OFS_DATA) && !(bus_wr && bus_addr == OFS_CTRL && bus_be[0]))
      |=> $stable(rem_q));

   p_scr_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && bus_addr == OFS_SCR && bus_be[0]) |=> $stable(scr_q));

   p_upper_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == OFS_DATA) |-> ((rd_rem & ~size_mask(size_q)) == 32'h0));
endmodule

// File: tb/crc_unit_tb.sv
`timescale 1ns/1ps
module crc_unit_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [3:0]  bus_be = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;

   int checks = 0, errors = 0;
   bit done = 0;

   logic [31:0] m_rem = 32'hFFFF_FFFF, m_init = 32'hFFFF_FFFF, m_poly = 32'h04C1_1DB7;
   logic [7:0]  m_scr = '0;
   logic [1:0]  m_size = 0, m_revi = 0;
   logic        m_revo = 0;

   always #10 clk = ~clk;

   crc_unit u_dut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
                   .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

   function automatic int deg(input logic [1:0] s);
      case (s) 2'd1: return 16; 2'd2: return 8; 2'd3: return 7; default: return 32; endcase
   endfunction

   function automatic logic [31:0] lowmask(input int n);
      return (n == 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 1);
   endfunction

   function automatic logic [31:0] m_reorder(input logic [31:0] d, input int mode, input int wc);
      int u, ub;
      logic [31:0] o;
      u = (mode < wc) ? mode : wc;
      if (u == 0) return d;
      ub = 8 << (u - 1);
      o = '0;
      for (int i = 0; i < 32; i++) o[(i/ub)*ub + ub - 1 - (i%ub)] = d[i];
      return o;
   endfunction

   function automatic logic [31:0] m_fold(input logic [31:0] r, input logic [31:0] p,
                                          input int n, input logic [31:0] d, input int w);
      logic [31:0] m;
      logic fb;
      m = lowmask(n);
      r = r & m;
      for (int i = w - 1; i >= 0; i--) begin
         fb = r[n-1] ^ d[i];
         r = (r << 1) & m;
         if (fb) r = r ^ (p & m);
      end
      return r;
   endfunction

   function automatic logic [31:0] m_readout();
      int n;
      logic [31:0] v, o;
      n = deg(m_size);
      v = m_rem & lowmask(n);
      if (!m_revo) return v;
      o = '0;
      for (int i = 0; i < n; i++) o[n-1-i] = v[i];
      return o;
   endfunction

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %08h expected %08h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
      int wc;
      @(negedge clk);
      bus_addr = a; bus_wr = 1'b1; bus_be = be; bus_wdata = d;
      @(posedge clk);
      #1 bus_wr = 1'b0;
      case (a)
         8'h00: begin
            wc = (be == 4'hF) ? 3 : (be == 4'h3) ? 2 : (be == 4'h1) ? 1 : 0;
            if (wc != 0)
               m_rem = m_fold(m_rem, m_poly, deg(m_size), m_reorder(d, m_revi, wc), 8 << (wc - 1));
         end
         8'h04: if (be[0]) m_scr = d[7:0];
         8'h08: if (be[0]) begin
            m_size = d[4:3]; m_revi = d[6:5]; m_revo = d[7];
            if (d[0]) m_rem = m_init;
         end
         8'h10: for (int b = 0; b < 4; b++) if (be[b]) m_init[8*b +: 8] = d[8*b +: 8];
         8'h14: for (int b = 0; b < 4; b++) if (be[b]) m_poly[8*b +: 8] = d[8*b +: 8];
         default: ;
      endcase
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wr = 1'b0;
      #2 d = bus_rdata;
   endtask

   task automatic chk_data(input string tag);
      logic [31:0] v;
      rd(8'h00, v);
      chk(tag, v, m_readout());
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [31:0] v;
      int r;
      void'($urandom(32'h1DB7_C0DE));
      repeat (3) @(posedge clk);
      rst_n = 1'b1;

      rd(8'h00, v); chk("R1 data", v, 32'hFFFF_FFFF);
      rd(8'h10, v); chk("R1 init", v, 32'hFFFF_FFFF);
      rd(8'h14, v); chk("R1 poly", v, 32'h04C1_1DB7);
      rd(8'h08, v); chk("R1 ctrl", v, 32'h0);

      wr(8'h00, 4'hF, 32'h1234_5678); chk_data("R3 word");
      wr(8'h00, 4'hF, 32'hDEAD_BEEF); wr(8'h00, 4'hF, 32'h0000_0001);
      wr(8'h00, 4'hF, 32'h8000_0000); chk_data("R10 back-to-back");
      wr(8'h00, 4'h3, 32'hFFFF_ABCD); chk_data("R4 half");
      wr(8'h00, 4'h1, 32'hFFFF_FF5A); chk_data("R4 byte");
      wr(8'h00, 4'h2, 32'h1111_1111); chk_data("R5 lane 0010");
      wr(8'h00, 4'hC, 32'h2222_2222); chk_data("R5 lane 1100");
      wr(8'h00, 4'h7, 32'h3333_3333); chk_data("R5 lane 0111");

      wr(8'h10, 4'hF, 32'hA5A5_0F0F);
      wr(8'h08, 4'h1, 32'h0000_0001);
      rd(8'h00, v); chk("R2 reload", v, 32'hA5A5_0F0F);
      rd(8'h08, v); chk("R2 ctrl bit0 reads 0", v, 32'h0);
      wr(8'h08, 4'h1, 32'hFFFF_FFF8);
      rd(8'h08, v); chk("R2 ctrl readback", v, 32'h0000_00F8);
      wr(8'h08, 4'h1, 32'h0);

      wr(8'h04, 4'h1, 32'h0000_005A);
      rd(8'h04, v); chk("R9 scratch", v, 32'h0000_005A);
      chk_data("R9 remainder untouched");

      for (int s = 1; s < 4; s++) begin
         wr(8'h14, 4'hF, (s == 1) ? 32'h0000_1021 : (s == 2) ? 32'h0000_0007 : 32'h0000_0009);
         for (int mo = 0; mo < 2; mo++) begin
            wr(8'h08, 4'h1, (mo << 7) | (s << 3) | 1);
            chk_data($sformatf("R6 reload size %0d", s));
            wr(8'h00, 4'hF, 32'hC0FF_EE11); wr(8'h00, 4'h1, 32'h0000_00E7);
            chk_data(mo ? $sformatf("R8 mirror size %0d", s) : $sformatf("R6 size %0d", s));
         end
      end
      wr(8'h14, 4'hF, 32'h04C1_1DB7);
      wr(8'h08, 4'h1, 32'h81); wr(8'h00, 4'hF, 32'h0F1E_2D3C);
      chk_data("R8 mirror size 32");

      for (int m = 1; m < 4; m++) begin
         wr(8'h08, 4'h1, (m << 5) | 1);
         wr(8'h00, 4'hF, 32'h0123_4567); chk_data($sformatf("R7 mode %0d word", m));
         wr(8'h00, 4'h3, 32'h0000_89AB); chk_data($sformatf("R7 mode %0d half", m));
         wr(8'h00, 4'h1, 32'h0000_00C3); chk_data($sformatf("R7 mode %0d byte", m));
      end

      for (int k = 0; k < 1500; k++) begin
         r = $urandom_range(0, 19);
         if (r == 0) wr(8'h08, 4'h1, $urandom & 32'hF9);
         else if (r == 1) wr(8'h10, 4'hF, $urandom);
         else if (r == 2) wr(8'h14, 4'hF, $urandom | 32'h1);
         else if (r == 3) wr(8'h04, 4'h1, $urandom);
         else if (r == 4) wr(8'h00, 4'($urandom), $urandom);
         else if (r < 9) wr(8'h00, 4'h1, $urandom);
         else if (r < 13) wr(8'h00, 4'h3, $urandom);
         else if (r < 17) wr(8'h00, 4'hF, $urandom);
         else if (r == 17) begin rd(8'h04, v); chk("R9 random scratch", v, {24'h0, m_scr}); end
         else chk_data("R3 R7 R8 random");
      end
      chk_data("R10 random end");

      finish_run();
   end
endmodule